// File: doc/BRIEF.md
# SIMD Byte-Immediate Logic Unit

This unit is a registered execution stage for a 128-bit vector datapath. It takes a source vector, the current contents of the destination vector and an 8-bit immediate, and it applies one of seven bitwise operations. Before use, the immediate is replicated into all sixteen byte positions to form a 128-bit mask.

Four of the operations are plain logic between the source and the mask: AND, OR, NOR and XOR. The other three merge the old destination with the source. Two of them use the mask to choose, either passing the source where mask bits are set or passing it where mask bits are clear. The third uses the destination itself as the per-bit selector, choosing between the source and the mask.

The datapath is split into two identical 64-bit lanes. Bits 0–63 form the low lane. The result and its valid flag appear one clock after the input strobe.

Top module: `byte_imm_logic_unit`

## Requirements
- R1: The mask is the 8-bit immediate copied into every one of the sixteen bytes, so each byte of every result is computed against the same 8-bit pattern.
- R2: Opcode 0 (AND) gives source AND mask.
- R3: Opcode 1 (OR) gives source OR mask, and opcode 2 (NOR) gives NOT (source OR mask).
- R4: Opcode 3 (XOR) gives source XOR mask.
- R5: Opcode 4 (move where mask set) gives (source AND mask) OR (destination AND NOT mask).
- R6: Opcode 5 (move where mask clear) gives (source AND NOT mask) OR (destination AND mask).
- R7: Opcode 6 (destination-selected) gives (source AND NOT destination) OR (mask AND destination).
- R8: Opcode 7 is reserved. It produces an all-zero result and raises `illegal_o` alongside `valid_o`.
- R9: `result_o`, `valid_o` and `illegal_o` update on the clock edge that samples `valid_i` high, so each result is visible one cycle after its inputs. `illegal_o` is never high without `valid_o`.
- R10: In a cycle with `valid_i` low, `result_o` keeps its previous value and `valid_o` and `illegal_o` are low at the next edge.
- R11: While `rst_ni` is low, `result_o`, `valid_o` and `illegal_o` are all zero.
- R12: For the two mask-merge operations, immediate 0xFF returns the pure source (opcode 4) or the pure destination (opcode 5), and immediate 0x00 returns the reverse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operand strobe |
| op_i | input | 3 | Operation code (0–6 valid, 7 reserved) |
| src_i | input | 128 | Source vector |
| dst_i | input | 128 | Current destination vector |
| imm_i | input | 8 | Byte immediate |
| result_o | output | 128 | Registered result |
| valid_o | output | 1 | Result valid |
| illegal_o | output | 1 | Reserved opcode seen |

## Verification
The hardest behaviour to reach is the interaction between every immediate bit and every operand bit in the merge operations. A wrong mask byte, or a swapped mask polarity, only shows up when the immediate, source and destination bits differ in the same position. To cover this, the stimulus sweeps all 256 immediates under every opcode. It uses several source/destination pairs whose bits disagree in many positions, including a pair that is exact complements. The 0x00 and 0xFF immediates are checked a second time against the pure source or pure destination outcome.

// File: rtl/byte_imm_pkg.sv
package byte_imm_pkg;
  typedef enum logic [2:0] {
    OP_AND   = 3'd0,
    OP_OR    = 3'd1,
    OP_NOR   = 3'd2,
    OP_XOR   = 3'd3,
    OP_MVSET = 3'd4,
    OP_MVCLR = 3'd5,
    OP_DSEL  = 3'd6,
    OP_RSVD  = 3'd7
  } op_e;
endpackage

// File: rtl/byte_imm_mask.sv
module byte_imm_mask #(
  parameter int IMM_W  = 8,
  parameter int DATA_W = 128
) (
  input  logic [IMM_W-1:0]  imm_i,
  output logic [DATA_W-1:0] mask_o
);
  localparam int NUM_SLOTS = DATA_W / IMM_W;

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    assign mask_o[g*IMM_W +: IMM_W] = imm_i;
  end
endmodule

// File: rtl/byte_imm_lane.sv
module byte_imm_lane
  import byte_imm_pkg::*;
#(
  parameter int LANE_W = 64
) (
  input  op_e               op_i,
  input  logic [LANE_W-1:0] src_i,
  input  logic [LANE_W-1:0] dst_i,
  input  logic [LANE_W-1:0] mask_i,
  output logic [LANE_W-1:0] res_o
);
  always_comb begin
    unique case (op_i)
      OP_AND:   res_o = src_i & mask_i;
      OP_OR:    res_o = src_i | mask_i;
      OP_NOR:   res_o = ~(src_i | mask_i);
      OP_XOR:   res_o = src_i ^ mask_i;
      OP_MVSET: res_o = (src_i & mask_i) | (dst_i & ~mask_i);
      OP_MVCLR: res_o = (src_i & ~mask_i) | (dst_i & mask_i);
      // destination bits pick mask (1) or source (0)
      OP_DSEL:  res_o = (src_i & ~dst_i) | (mask_i & dst_i);
      default:  res_o = '0;
    endcase
  end
endmodule

// File: rtl/byte_imm_logic_unit.sv
module byte_imm_logic_unit
  import byte_imm_pkg::*;
#(
  parameter int DATA_W = 128,
  parameter int LANE_W = 64,
  parameter int IMM_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [2:0]        op_i,
  input  logic [DATA_W-1:0] src_i,
  input  logic [DATA_W-1:0] dst_i,
  input  logic [IMM_W-1:0]  imm_i,
  output logic [DATA_W-1:0] result_o,
  output logic              valid_o,
  output logic              illegal_o
);
  localparam int NUM_LANES = DATA_W / LANE_W;

  op_e               op;
  logic [DATA_W-1:0] mask;
  logic [DATA_W-1:0] res_d;
  logic              rsvd;
  logic [DATA_W-1:0] res_q;
  logic              valid_q;
  logic              illegal_q;

  assign op   = op_e'(op_i);
  assign rsvd = (op == OP_RSVD);

  byte_imm_mask #(
    .IMM_W (IMM_W),
    .DATA_W(DATA_W)
  ) u_mask (
    .imm_i (imm_i),
    .mask_o(mask)
  );

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    byte_imm_lane #(
      .LANE_W(LANE_W)
    ) u_lane (
      .op_i  (op),
      .src_i (src_i[l*LANE_W +: LANE_W]),
      .dst_i (dst_i[l*LANE_W +: LANE_W]),
      .mask_i(mask[l*LANE_W +: LANE_W]),
      .res_o (res_d[l*LANE_W +: LANE_W])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q     <= '0;
      valid_q   <= 1'b0;
      illegal_q <= 1'b0;
    end else begin
      valid_q   <= valid_i;
      illegal_q <= valid_i & rsvd;
      if (valid_i) res_q <= res_d;
    end
  end

  assign result_o  = res_q;
  assign valid_o   = valid_q;
  assign illegal_o = illegal_q;
endmodule

// File: rtl/byte_imm_logic_unit_chk.sv
module byte_imm_logic_unit_chk #(
  parameter int DATA_W = 128,
  parameter int IMM_W  = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [2:0]        op_i,
  input logic [DATA_W-1:0] src_i,
  input logic [IMM_W-1:0]  imm_i,
  input logic [DATA_W-1:0] result_o,
  input logic              valid_o,
  input logic              illegal_o
);
  localparam int REPS = DATA_W / IMM_W;

  logic seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= 1'b0;
    else         seen_q <= 1'b1;
  end

  p_valid_latency_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q |-> (valid_o == $past(valid_i)));

  p_illegal_with_valid_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> valid_o);

  p_rsvd_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> (result_o == '0));

  p_hold_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && !$past(valid_i)) |-> ($stable(result_o) && !valid_o));

  p_and_result_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && $past(valid_i) && $past(op_i) == 3'd0)
      |-> (result_o == ($past(src_i) & {REPS{$past(imm_i)}})));
endmodule

bind byte_imm_logic_unit byte_imm_logic_unit_chk #(
  .DATA_W(DATA_W),
  .IMM_W (IMM_W)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .valid_i  (valid_i),
  .op_i     (op_i),
  .src_i    (src_i),
  .imm_i    (imm_i),
  .result_o (result_o),
  .valid_o  (valid_o),
  .illegal_o(illegal_o)
);

// File: tb/byte_imm_logic_unit_tb.sv
`timescale 1ns/1ps
module byte_imm_logic_unit_tb;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         valid_i = 1'b0;
  logic [2:0]   op_i = '0;
  logic [127:0] src_i = '0;
  logic [127:0] dst_i = '0;
  logic [7:0]   imm_i = '0;
  logic [127:0] result_o;
  logic         valid_o;
  logic         illegal_o;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 0;

  always #2.5 clk_i = ~clk_i;

  byte_imm_logic_unit u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i),
    .src_i(src_i), .dst_i(dst_i), .imm_i(imm_i),
    .result_o(result_o), .valid_o(valid_o), .illegal_o(illegal_o)
  );

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] model(input logic [2:0] op, input logic [127:0] s,
                                         input logic [127:0] d, input logic [7:0] imm);
    logic [127:0] m;
    for (int b = 0; b < 16; b++) m[b*8 +: 8] = imm;
    case (op)
      3'd0: return s & m;
      3'd1: return s | m;
      3'd2: return ~(s | m);
      3'd3: return s ^ m;
      3'd4: return (s & m) | (d & ~m);
      3'd5: return (s & ~m) | (d & m);
      3'd6: return (s & ~d) | (m & d);
      default: return '0;
    endcase
  endfunction

  function automatic string tag(input logic [2:0] op);
    case (op)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4: return "R5";
      3'd5: return "R6";
      3'd6: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic apply(input logic [2:0] op, input logic [127:0] s,
                       input logic [127:0] d, input logic [7:0] imm);
    @(negedge clk_i);
    valid_i = 1'b1; op_i = op; src_i = s; dst_i = d; imm_i = imm;
    @(posedge clk_i); #1;
    chk(tag(op), result_o, model(op, s, d, imm));
    chk("R9", {127'd0, valid_o}, 128'd1);
    chk("R8", {127'd0, illegal_o}, {127'd0, (op == 3'd7)});
    if (imm == 8'hFF && op == 3'd4) chk("R12", result_o, s);
    if (imm == 8'h00 && op == 3'd4) chk("R12", result_o, d);
    if (imm == 8'hFF && op == 3'd5) chk("R12", result_o, d);
    if (imm == 8'h00 && op == 3'd5) chk("R12", result_o, s);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    n_vec++; n_bad++;
    $display("FAIL watchdog act=timeout exp=done");
    finish_run();
  end

  initial begin
    logic [127:0] srcs [4];
    logic [127:0] dsts [4];
    logic [127:0] held;
    srcs[0] = 128'hf7a594aec8ef8a9c_1169751bb9a7d9c3;
    dsts[0] = 128'h4f41ffdef2bfe636_f35862e13e38f8b0;
    srcs[1] = 128'h3a0d80d68b3f8bc8_2b665362c4e812df;
    dsts[1] = ~srcs[1];
    srcs[2] = 128'h0;
    dsts[2] = {128{1'b1}};
    srcs[3] = 128'h0123456789abcdef_fedcba9876543210;
    dsts[3] = 128'h55aa55aa33cc33cc_0ff00ff0f00ff00f;

    repeat (3) @(posedge clk_i);
    #1;
    chk("R11", result_o, '0);
    chk("R11", {126'd0, valid_o, illegal_o}, '0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R1: AND with all-ones source exposes the replicated mask
    apply(3'd0, {128{1'b1}}, '0, 8'h5c);
    chk("R1", result_o, {16{8'h5c}});

    for (int p = 0; p < 4; p++)
      for (int op = 0; op < 8; op++)
        for (int imm = 0; imm < 256; imm++)
          apply(3'(op), srcs[p], dsts[p], 8'(imm));

    // R10: idle cycle holds result, drops valid
    apply(3'd3, srcs[3], dsts[3], 8'ha7);
    held = result_o;
    @(negedge clk_i);
    valid_i = 1'b0; src_i = ~src_i; op_i = 3'd7;
    @(posedge clk_i); #1;
    chk("R10", result_o, held);
    chk("R10", {126'd0, valid_o, illegal_o}, '0);

    // R11: asynchronous reset mid-run clears outputs
    apply(3'd1, srcs[0], dsts[0], 8'h3b);
    #1 rst_ni = 1'b0;
    #1;
    chk("R11", result_o, '0);
    chk("R11", {126'd0, valid_o, illegal_o}, '0);
    finish_run();
  end
endmodule